// File: doc/BRIEF.md
# Cascaded 16-line interrupt acknowledge unit

This block joins two 8-line interrupt resolvers into one 16-line unit. Lines 0 to 7 enter the primary resolver and lines 8 to 15 enter the secondary. Whenever the secondary holds a winning request, it posts a request on primary line 2, the cascade line. The CPU sees one interrupt output. When the CPU pulses its acknowledge, the block accepts the primary winner and, if that winner is the cascade line, also the secondary winner. One cycle later it returns an 8-bit vector.

The vector is made from a programmed 5-bit base in its upper bits and the 3-bit line number in its lower bits. If a request has vanished by acknowledge time, the block reports line 7 as a spurious interrupt. This applies at either level. Priority is fixed: a lower line index wins. A request is taken only if it outranks every line that is still in service. An optional nesting mode lets the primary leave the cascade line out of that comparison, so a higher secondary line can interrupt a lower one. Programming of bases, masks and modes happens elsewhere and reaches the block as plain inputs. An end-of-service pulse per resolver closes the highest-priority line in service.

Top module: `pic_cascade`

## Requirements
- R1: After reset, int_o and vec_valid_o are low and no request, service or edge history is held.
- R2: On an edge-type line, a 0-to-1 transition latches a request, and int_o rises one cycle after the clock that sampled it. A line held high after its acknowledge does not request again.
- R3: A line is level-type only when its level_sel_i bit is set and the line is level-capable. Primary lines 3 to 7 and secondary lines 1 to 4, 6 and 7 (masks 0xF8 and 0xDE) are level-capable. A level request follows the input and is not cleared by acknowledge. A select bit on any other line leaves that line edge-type.
- R4: A line whose mask_i bit is 1 cannot win or raise int_o. Its latched request wins once the mask bit clears.
- R5: Among unmasked pending lines, the lowest index wins. It is taken only if its index is below that of every line in service.
- R6: Acknowledging a primary winner other than line 2 marks it in service, clears it if edge-type, and returns vector {pri_base_i, line} with spur_o low. vec_valid_o is high for exactly the cycle after inta_i.
- R7: A secondary winner sets primary line 2 one cycle later. Acknowledging line 2 also acknowledges the secondary winner and returns {sec_base_i, secondary line}.
- R8: If the primary has no winner at acknowledge time, the vector is {pri_base_i, 3'd7}, spur_o is high, and no state changes.
- R9: If the primary takes line 2 but the secondary has no winner, the vector is {sec_base_i, 3'd7}, spur_o is high, and only the primary marks line 2 in service.
- R10: With nest_mode_i high, primary in-service line 2 is left out of the primary's priority comparison.
- R11: eoi_i[0] (primary) and eoi_i[1] (secondary) each clear the lowest-index in-service bit of their resolver.
- R12: int_o is high exactly while the primary has a winner. It is re-evaluated in the cycle after every acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Request lines; 7:0 primary, 15:8 secondary |
| mask_i | input | 16 | Per-line mask, 1 blocks the line |
| level_sel_i | input | 16 | Per-line level-type select, gated by the level-capable masks |
| pri_base_i | input | 5 | Primary vector base, upper vector bits |
| sec_base_i | input | 5 | Secondary vector base, upper vector bits |
| nest_mode_i | input | 1 | Primary ignores in-service line 2 when ranking |
| inta_i | input | 1 | CPU acknowledge pulse |
| eoi_i | input | 2 | End-of-service pulse per resolver |
| int_o | output | 1 | Interrupt to CPU |
| vec_o | output | 8 | Vector from last acknowledge |
| vec_valid_o | output | 1 | vec_o updated in the previous cycle |
| spur_o | output | 1 | Last acknowledge was spurious |

## Verification
The bench drives single primary edges, two simultaneous primary edges, and a masked line that is later released. These show the edge latch, the lowest-index rule, the in-service block and the mask. Secondary edges then run through the cascade. A secondary level request dropped before its acknowledge separates a real cascade vector from the secondary spurious one. A primary level line acknowledged and then closed shows that level requests survive acknowledge. A select bit on a line that cannot be level-type shows that the line stays edge-type. A nested secondary request made while line 2 is in service is tried with the nesting mode off and then on. A behavioural model follows every cycle to catch any divergence between these points.

// File: rtl/pic_cascade_pkg.sv
`timescale 1ns/1ps
package pic_cascade_pkg;
  localparam int LINES     = 8;
  localparam int LINE_W    = $clog2(LINES);
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - LINE_W;
  localparam int CASC_LINE = 2;
  localparam logic [LINE_W-1:0] SPUR_LINE = LINE_W'(LINES - 1);
  localparam logic [LINES-1:0]  LVL_OK_PRI = 8'hF8;
  localparam logic [LINES-1:0]  LVL_OK_SEC = 8'hDE;
endpackage

// File: rtl/pic_prio_pick.sv
`timescale 1ns/1ps
// Rank of lowest set bit; N when empty.
module pic_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W:0]   rank_o
);
  always_comb begin
    rank_o = (W+1)'(N);
    for (int i = N - 1; i >= 0; i--)
      if (vec_i[i]) rank_o = (W+1)'(i);
  end
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] pulse_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] isr_ign_i,
  input  logic         ack_i,
  input  logic         eoi_i,
  output logic         win_o,
  output logic [W-1:0] line_o
);
  logic [N-1:0] irr_q, last_q, isr_q;
  logic [N-1:0] ack_set, eoi_clr, edge_set;
  logic [W:0]   pend_rank, busy_rank, eoi_rank;

  pic_prio_pick #(.N(N)) i_pend (.vec_i(irr_q & ~mask_i),    .rank_o(pend_rank));
  pic_prio_pick #(.N(N)) i_busy (.vec_i(isr_q & ~isr_ign_i), .rank_o(busy_rank));
  pic_prio_pick #(.N(N)) i_eoi  (.vec_i(isr_q),              .rank_o(eoi_rank));

  assign win_o  = pend_rank < busy_rank;
  assign line_o = pend_rank[W-1:0];

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (ack_i && win_o) ack_set[line_o] = 1'b1;
    if (eoi_i && !eoi_rank[W]) eoi_clr[eoi_rank[W-1:0]] = 1'b1;
  end

  assign edge_set = (req_i & ~last_q) | pulse_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
    end else begin
      // acknowledge clear wins over a same-cycle edge on edge-type lines
      irr_q  <= (lvl_i & req_i) | (~lvl_i & ((irr_q | edge_set) & ~ack_set));
      last_q <= req_i;
      isr_q  <= (isr_q | ack_set) & ~eoi_clr;
    end
  end

  assert_isr_mark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && win_o && !eoi_i |=> isr_q[$past(line_o)]);

  generate
    for (genvar k = 0; k < N; k++) begin : g_chk
      assert_edge_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i[k]) && !lvl_i[k] && !(ack_i && win_o && line_o == W'(k)) |=> irr_q[k]);
      assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_i[k] |=> irr_q[k] == $past(req_i[k]));
      assert_mask_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i[k] |-> !(win_o && line_o == W'(k)));
    end
  endgenerate
endmodule

// File: rtl/pic_cascade.sv
`timescale 1ns/1ps
module pic_cascade
  import pic_cascade_pkg::*;
#(
  parameter logic [LINES-1:0] PRI_LVL_OK = LVL_OK_PRI,
  parameter logic [LINES-1:0] SEC_LVL_OK = LVL_OK_SEC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*LINES-1:0]      irq_i,
  input  logic [2*LINES-1:0]      mask_i,
  input  logic [2*LINES-1:0]      level_sel_i,
  input  logic [VEC_W-1:LINE_W]   pri_base_i,
  input  logic [VEC_W-1:LINE_W]   sec_base_i,
  input  logic                    nest_mode_i,
  input  logic                    inta_i,
  input  logic [1:0]              eoi_i,
  output logic                    int_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic                    vec_valid_o,
  output logic                    spur_o
);
  localparam logic [LINES-1:0]  CASC_BIT = LINES'(1) << CASC_LINE;
  localparam logic [LINE_W-1:0] CASC_IDX = LINE_W'(CASC_LINE);

  logic              pri_win, sec_win, sec_ack, pri_casc;
  logic [LINE_W-1:0] pri_line, sec_line;

  assign pri_casc = pri_win && (pri_line == CASC_IDX);
  assign sec_ack  = inta_i && pri_casc;

  pic_ctrl #(.N(LINES)) i_sec (
    .clk_i, .rst_ni,
    .req_i    (irq_i[2*LINES-1:LINES]),
    .pulse_i  ('0),
    .lvl_i    (level_sel_i[2*LINES-1:LINES] & SEC_LVL_OK),
    .mask_i   (mask_i[2*LINES-1:LINES]),
    .isr_ign_i('0),
    .ack_i    (sec_ack),
    .eoi_i    (eoi_i[1]),
    .win_o    (sec_win),
    .line_o   (sec_line)
  );

  pic_ctrl #(.N(LINES)) i_pri (
    .clk_i, .rst_ni,
    .req_i    (irq_i[LINES-1:0]),
    .pulse_i  (sec_win ? CASC_BIT : '0),
    .lvl_i    (level_sel_i[LINES-1:0] & PRI_LVL_OK),
    .mask_i   (mask_i[LINES-1:0]),
    .isr_ign_i(nest_mode_i ? CASC_BIT : '0),
    .ack_i    (inta_i),
    .eoi_i    (eoi_i[0]),
    .win_o    (pri_win),
    .line_o   (pri_line)
  );

  assign int_o = pri_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      spur_o      <= 1'b0;
    end else begin
      vec_valid_o <= inta_i;
      if (inta_i) begin
        if (!pri_win) begin
          vec_o  <= {pri_base_i, SPUR_LINE};
          spur_o <= 1'b1;
        end else if (pri_casc) begin
          vec_o  <= {sec_base_i, sec_win ? sec_line : SPUR_LINE};
          spur_o <= !sec_win;
        end else begin
          vec_o  <= {pri_base_i, pri_line};
          spur_o <= 1'b0;
        end
      end
    end
  end

  assert_ack_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_valid_o);
  assert_spur_pri_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && !int_o |=> spur_o && vec_o == {$past(pri_base_i), SPUR_LINE});
  assert_cascade_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && pri_casc && sec_win |=> !spur_o && vec_o[VEC_W-1:LINE_W] == $past(sec_base_i));
  assert_spur_sec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && pri_casc && !sec_win |=> spur_o && vec_o == {$past(sec_base_i), SPUR_LINE});
endmodule

// File: tb/test_pic_cascade.sv
`timescale 1ns/1ps
module test_pic_cascade;
  logic        clk_i = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0, msk = '0, lvl = '0;
  logic [4:0]  pb = 5'b00100, sb = 5'b01110;   // bases 0x20 and 0x70
  logic        nest = 1'b0, inta = 1'b0;
  logic [1:0]  eoi = '0;
  logic        int_o, vec_valid, spur;
  logic [7:0]  vec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pic_cascade i_pic_cascade (
    .clk_i, .rst_ni(rst_n), .irq_i(irq), .mask_i(msk), .level_sel_i(lvl),
    .pri_base_i(pb), .sec_base_i(sb), .nest_mode_i(nest), .inta_i(inta),
    .eoi_i(eoi), .int_o, .vec_o(vec), .vec_valid_o(vec_valid), .spur_o(spur)
  );

  // behavioural reference model
  bit [7:0] m_irr[2], m_last[2], m_isr[2];
  int m_vec; bit m_valid, m_spur;

  function automatic int first_set(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int win_line(int c);
    bit [7:0] m   = (c == 0) ? msk[7:0] : msk[15:8];
    bit [7:0] ign = (c == 0 && nest) ? 8'h04 : 8'h00;
    int p = first_set(m_irr[c] & ~m);
    int b = first_set(m_isr[c] & ~ign);
    return (p < b) ? p : -1;
  endfunction

  always @(posedge clk_i or negedge rst_n) begin : model
    int pl, sl, lv, rq;
    bit [7:0] ackm[2], eoim[2], okm;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin m_irr[c] = 0; m_last[c] = 0; m_isr[c] = 0; end
      m_valid = 0; m_spur = 0; m_vec = 0;
    end else begin
      pl = win_line(0); sl = win_line(1);
      ackm[0] = 0; ackm[1] = 0; eoim[0] = 0; eoim[1] = 0;
      m_valid = inta;
      if (inta) begin
        if (pl < 0) begin m_vec = {pb, 3'd7}; m_spur = 1; end
        else begin
          ackm[0][pl] = 1;
          if (pl == 2) begin
            if (sl >= 0) begin ackm[1][sl] = 1; m_vec = {sb, 3'(sl)}; m_spur = 0; end
            else begin m_vec = {sb, 3'd7}; m_spur = 1; end
          end else begin m_vec = {pb, 3'(pl)}; m_spur = 0; end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (eoi[c] && m_isr[c] != 0) eoim[c][first_set(m_isr[c])] = 1;
        okm = (c == 0) ? 8'hF8 : 8'hDE;
        for (int i = 0; i < 8; i++) begin
          lv = lvl[c*8+i] && okm[i];
          rq = irq[c*8+i];
          if (lv) m_irr[c][i] = rq[0];
          else begin
            if ((rq && !m_last[c][i]) || (c == 0 && i == 2 && sl >= 0)) m_irr[c][i] = 1;
            if (ackm[c][i]) m_irr[c][i] = 0;
          end
          m_last[c][i] = rq[0];
        end
        m_isr[c] = (m_isr[c] | ackm[c]) & ~eoim[c];
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (rst_n && !done) begin
      chk(int_o == (win_line(0) >= 0), "R12 int_o vs model", int'(int_o), int'(win_line(0) >= 0));
      chk(vec_valid == m_valid, "R6 vec_valid vs model", int'(vec_valid), int'(m_valid));
      if (m_valid) begin
        chk(vec == m_vec, "R6 vector vs model", vec, m_vec);
        chk(spur == m_spur, "R8 spur vs model", int'(spur), int'(m_spur));
      end
    end
  end

  task automatic expect_int(int n, bit e, string tag);
    repeat (n) @(negedge clk_i);
    #1;
    chk(int_o == e, tag, int'(int_o), int'(e));
  endtask

  task automatic do_ack(int ev, bit es, string tag);
    @(negedge clk_i); inta = 1;
    @(negedge clk_i); inta = 0;
    #1;
    chk(vec_valid && vec == ev && spur == es, tag, {vec_valid, spur, vec}, {1'b1, es, 8'(ev)});
  endtask

  task automatic do_eoi(bit [1:0] e);
    @(negedge clk_i); eoi = e;
    @(negedge clk_i); eoi = 0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!int_o && !vec_valid, "R1 reset outputs", {int_o, vec_valid}, 0);
    @(negedge clk_i); rst_n = 1;
    expect_int(1, 0, "R1 idle after reset");

    do_ack(8'h27, 1, "R8 primary spurious");

    // edge line, held high after ack
    @(negedge clk_i); irq[5] = 1;
    expect_int(1, 1, "R2 edge raises int_o");
    do_ack(8'h25, 0, "R6 primary vector");
    expect_int(1, 0, "R12 int_o drops after ack; R2 no re-request");
    do_eoi(2'b01);
    expect_int(1, 0, "R11 eoi with held edge line stays quiet");
    @(negedge clk_i); irq[5] = 0;

    // priority and in-service blocking
    @(negedge clk_i); irq[3] = 1; irq[6] = 1;
    expect_int(1, 1, "R5 two pending");
    do_ack(8'h23, 0, "R5 lowest index wins");
    expect_int(1, 0, "R5 lower line blocked by in-service");
    do_ack(8'h27, 1, "R8 spurious while blocked");
    do_eoi(2'b01);
    expect_int(1, 1, "R11 eoi releases blocked line");
    do_ack(8'h26, 0, "R5 second line");
    do_eoi(2'b01);
    @(negedge clk_i); irq[3] = 0; irq[6] = 0;

    // mask
    @(negedge clk_i); msk[4] = 1; irq[4] = 1;
    expect_int(2, 0, "R4 masked line silent");
    @(negedge clk_i); msk[4] = 0;
    expect_int(0, 1, "R4 unmask releases request");
    do_ack(8'h24, 0, "R4 vector after unmask");
    do_eoi(2'b01);
    @(negedge clk_i); irq[4] = 0;

    // cascade
    @(negedge clk_i); irq[13] = 1;
    expect_int(1, 0, "R7 one cycle through secondary");
    expect_int(1, 1, "R7 cascade raises int_o");
    do_ack(8'h75, 0, "R7 secondary vector");
    expect_int(1, 0, "R12 after cascade ack");
    do_eoi(2'b11);
    @(negedge clk_i); irq[13] = 0;

    // secondary request vanishes
    @(negedge clk_i); lvl[11] = 1; irq[11] = 1;
    expect_int(2, 1, "R3 level on secondary");
    @(negedge clk_i); irq[11] = 0;
    expect_int(1, 1, "R9 cascade request stays latched");
    do_ack(8'h77, 1, "R9 secondary spurious");
    do_eoi(2'b01);
    @(negedge clk_i); lvl[11] = 0;

    // primary level line survives ack
    @(negedge clk_i); lvl[7] = 1; irq[7] = 1;
    expect_int(1, 1, "R3 level request");
    do_ack(8'h27, 0, "R3 level line vector not spurious");
    expect_int(1, 0, "R3 level line in service");
    do_eoi(2'b01);
    expect_int(1, 1, "R3 level request survives ack");
    @(negedge clk_i); irq[7] = 0;
    expect_int(1, 0, "R3 level release");
    @(negedge clk_i); lvl[7] = 0;

    // select on a line that cannot be level
    @(negedge clk_i); lvl[1] = 1; irq[1] = 1;
    expect_int(1, 1, "R3 line 1 request");
    do_ack(8'h21, 0, "R3 line 1 vector");
    do_eoi(2'b01);
    expect_int(1, 0, "R3 line 1 stays edge-type");
    @(negedge clk_i); lvl[1] = 0; irq[1] = 0;

    // nesting mode
    @(negedge clk_i); irq[13] = 1;
    expect_int(2, 1, "R7 cascade for nesting test");
    do_ack(8'h75, 0, "R7 secondary line 5");
    @(negedge clk_i); irq[11] = 1;
    expect_int(2, 0, "R10 nested secondary blocked in normal mode");
    @(negedge clk_i); nest = 1;
    expect_int(0, 1, "R10 nesting mode lets cascade through");
    do_ack(8'h73, 0, "R10 nested secondary vector");
    do_eoi(2'b10);
    do_eoi(2'b10);
    do_eoi(2'b01);
    @(negedge clk_i); nest = 0; irq[13] = 0; irq[11] = 0;
    expect_int(2, 0, "R11 all service closed");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule